// File: doc/BRIEF.md
# Flash Programming Sequence Controller

This block guards flash programming commands behind a two-write unlock. Software issues a control write whose upper nibble is 5h and then, in the very next cycle, a control write whose upper nibble is Ah. The lower nibble of that second write selects the command. The block checks this handshake and keeps three status flags: busy, sequence error and latch-loaded. When a command is accepted, it emits a one-clock start pulse and a command code to an external memory-timing model. That model answers with a done pulse some cycles later.

Column-latch loading is reported to the block by a load strobe. Power-down requests are granted at once when the flash is idle. A request that arrives during a programming operation is held until the operation ends. Entering power-down discards the contents of the column latches. An error stays set until software clears it, and any later good sequence also clears it without notice.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A control write with upper nibble 5h followed in the next cycle by a control write with upper nibble Ah and lower nibble 0h or 1h starts a command, provided the latch-loaded flag is set and busy is clear. In the cycle after the Ah write, `prog_start` is high for exactly one cycle and `busy` goes high.
- R2: After a 5h write, the sequence is broken by any of the following in the next cycle: a status write, an other-access cycle, an interrupt-flagged cycle, or an idle cycle with no control write. A break sets `seq_err` and starts nothing. An Ah write that comes later is then ignored.
- R3: After a 5h write, a control write whose upper nibble is not Ah (5h included) sets `seq_err` and starts nothing.
- R4: The lower nibble of the Ah write selects the command. 0h gives `prog_cmd`=0 (write flash). 1h gives `prog_cmd`=1 (reset column latches). Any other value sets `seq_err` and starts nothing.
- R5: A command sequence completed while `latch_loaded` is 0, or while `busy` is 1, sets `seq_err` and does not start.
- R6: `busy` clears in the cycle after `prog_done` is seen while busy. A `prog_done` pulse while not busy has no effect.
- R7: A status write with bit 1 = 0 clears `seq_err`. A status write with bit 1 = 1 leaves it unchanged. A correct, accepted sequence also clears `seq_err`.
- R8: A `latch_load` strobe sets `latch_loaded` in the next cycle. Completion of an operation clears it.
- R9: A `pd_req` pulse while not busy gives a one-cycle `pd_enter` in the next cycle and clears `latch_loaded`. A request made while busy is held, and `pd_enter` fires in the cycle after `busy` falls.
- R10: After reset, `busy`, `seq_err`, `latch_loaded`, `prog_start`, `prog_cmd` and `pd_enter` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| sts_wr | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data for either register |
| other_acc | input | 1 | Some other bus access in this cycle |
| irq_cycle | input | 1 | Interrupt-flagged cycle |
| latch_load | input | 1 | Column-latch load strobe |
| pd_req | input | 1 | Power-down request pulse |
| prog_done | input | 1 | Completion pulse from the timing model |
| prog_start | output | 1 | One-cycle operation start pulse |
| prog_cmd | output | 1 | Command code: 0 write flash, 1 reset latches |
| pd_enter | output | 1 | Power-down granted pulse |
| busy | output | 1 | Programming in progress |
| seq_err | output | 1 | Sticky sequence error flag |
| latch_loaded | output | 1 | Column latches hold data |

## Verification
The hardest situation to reach is a power-down request during a running operation. It needs a fully valid unlock with loaded latches first. The request must then stay silent until the done pulse and fire exactly one cycle after busy falls. The bench builds this with a load strobe, an unlock pair and a request, then holds back `prog_done` for several cycles before it pulses. A second sweep sends all 256 byte values as the follow-up to a 5h write and predicts the outcome from the nibbles alone.

// File: rtl/flash_seq_pkg.sv
// Package: shared constants for the flash programming sequence controller.
// Assumes 8-bit register data split into two 4-bit nibbles.
package flash_seq_pkg;
    localparam int DATA_W   = 8;
    localparam int NIB_W    = DATA_W / 2;
    localparam logic [NIB_W-1:0] KEY_FIRST  = 4'h5;
    localparam logic [NIB_W-1:0] KEY_SECOND = 4'hA;
    localparam int ERR_BIT  = 1;

    typedef enum logic [NIB_W-1:0] {
        OP_WRITE_FLASH = 4'h0,
        OP_RESET_LATCH = 4'h1
    } op_code_t;
endpackage

// File: rtl/flash_unlock_fsm.sv
// Unlock detector: arms on a clean first-key write, then judges the very next cycle.
// Assumes at most one bus access per cycle; brk_i covers every non-control access.
module flash_unlock_fsm
    import flash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic              brk_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cmd_req_o,
    output logic [NIB_W-1:0]  cmd_code_o,
    output logic              seq_fault_o
);
    logic armed_q;
    logic clean_wr;
    logic [NIB_W-1:0] hi_nib;

    assign hi_nib     = data_i[DATA_W-1:NIB_W];
    assign clean_wr   = ctl_wr_i && !brk_i;
    assign cmd_code_o = data_i[NIB_W-1:0];

    // Judge the cycle following an armed first key.
    always_comb begin
        cmd_req_o   = 1'b0;
        seq_fault_o = 1'b0;
        if (armed_q) begin
            cmd_req_o   = clean_wr && (hi_nib == KEY_SECOND);
            seq_fault_o = !cmd_req_o;
        end
    end

    // Arm only from idle on a clean first-key write; any armed cycle disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= !armed_q && clean_wr && (hi_nib == KEY_FIRST);
    end
endmodule

// File: rtl/flash_flag_bank.sv
// Flag bank: busy, sticky error and latch-loaded flags, plus the start pulse.
// Assumes the done pulse is meaningful only while busy.
module flash_flag_bank
    import flash_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_req_i,
    input  logic [NIB_W-1:0] cmd_code_i,
    input  logic             seq_fault_i,
    input  logic             err_clr_i,
    input  logic             latch_load_i,
    input  logic             pd_go_i,
    input  logic             done_i,
    output logic             prog_start_o,
    output logic             prog_cmd_o,
    output logic             busy_o,
    output logic             err_o,
    output logic             loaded_o
);
    logic code_ok;
    logic start;
    logic fault;
    logic finish;

    assign code_ok = (cmd_code_i == OP_WRITE_FLASH) || (cmd_code_i == OP_RESET_LATCH);
    assign start   = cmd_req_i && code_ok && loaded_o && !busy_o;
    assign fault   = seq_fault_i || (cmd_req_i && !start);
    assign finish  = busy_o && done_i;

    // Start pulse and command code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_start_o <= 1'b0;
            prog_cmd_o   <= 1'b0;
        end else begin
            prog_start_o <= start;
            if (start) prog_cmd_o <= cmd_code_i[0];
        end
    end

    // Busy: set on start, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_o <= 1'b0;
        else if (start)  busy_o <= 1'b1;
        else if (finish) busy_o <= 1'b0;
    end

    // Error: hardware set wins, then good sequence, then software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_o <= 1'b0;
        else if (fault)     err_o <= 1'b1;
        else if (start)     err_o <= 1'b0;
        else if (err_clr_i) err_o <= 1'b0;
    end

    // Latch-loaded: cleared by completion or power-down, set by load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                loaded_o <= 1'b0;
        else if (pd_go_i || finish) loaded_o <= 1'b0;
        else if (latch_load_i)     loaded_o <= 1'b1;
    end

    assert_pulse_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |=> !prog_start_o);
    assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> prog_start_o);
    assert_start_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_o |-> $past(loaded_o) && !$past(busy_o));
    assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_i));
endmodule

// File: rtl/flash_pd_gate.sv
// Power-down gate: grants requests when idle, holds them while busy.
// Assumes pd_req is a pulse; one pending request is remembered.
module flash_pd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req_i,
    input  logic busy_i,
    output logic pd_go_o,
    output logic pd_enter_o
);
    logic pend_q;

    assign pd_go_o = (pend_q || pd_req_i) && !busy_i;

    // Remember deferred requests and register the grant pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pd_enter_o <= 1'b0;
        end else begin
            pend_q     <= (pend_q || pd_req_i) && !pd_go_o;
            pd_enter_o <= pd_go_o;
        end
    end

    assert_no_pd_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_enter_o |-> !$past(busy_i));
endmodule

// File: rtl/flash_seq_ctrl.sv
// Top: flash programming sequence controller.
// Assumes one bus access per cycle and an external model that returns prog_done.
module flash_seq_ctrl
    import flash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              sts_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              other_acc,
    input  logic              irq_cycle,
    input  logic              latch_load,
    input  logic              pd_req,
    input  logic              prog_done,
    output logic              prog_start,
    output logic              prog_cmd,
    output logic              pd_enter,
    output logic              busy,
    output logic              seq_err,
    output logic              latch_loaded
);
    logic             brk;
    logic             cmd_req;
    logic [NIB_W-1:0] cmd_code;
    logic             seq_fault;
    logic             err_clr;
    logic             pd_go;

    assign brk     = sts_wr || other_acc || irq_cycle;
    assign err_clr = sts_wr && !wr_data[ERR_BIT];

    flash_unlock_fsm u_unlock (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .brk_i(brk), .data_i(wr_data),
        .cmd_req_o(cmd_req), .cmd_code_o(cmd_code), .seq_fault_o(seq_fault)
    );

    flash_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .cmd_req_i(cmd_req), .cmd_code_i(cmd_code),
        .seq_fault_i(seq_fault), .err_clr_i(err_clr), .latch_load_i(latch_load),
        .pd_go_i(pd_go), .done_i(prog_done), .prog_start_o(prog_start),
        .prog_cmd_o(prog_cmd), .busy_o(busy), .err_o(seq_err), .loaded_o(latch_loaded)
    );

    flash_pd_gate u_pd (
        .clk(clk), .rst_n(rst_n), .pd_req_i(pd_req), .busy_i(busy),
        .pd_go_o(pd_go), .pd_enter_o(pd_enter)
    );

    assert_key_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(ctl_wr, 2) && ($past(wr_data[DATA_W-1:NIB_W], 2) == KEY_FIRST)
                       && $past(ctl_wr) && ($past(wr_data[DATA_W-1:NIB_W]) == KEY_SECOND));
    assert_pd_clears_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_enter |-> !latch_loaded);
endmodule

// File: tb/flash_seq_ctrl_tb_top.sv
module flash_seq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, sts_wr = 0, other_acc = 0, irq_cycle = 0;
    logic latch_load = 0, pd_req = 0, prog_done = 0;
    logic [7:0] wr_data = 8'h00;
    logic prog_start, prog_cmd, pd_enter, busy, seq_err, latch_loaded;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .sts_wr(sts_wr), .wr_data(wr_data),
        .other_acc(other_acc), .irq_cycle(irq_cycle), .latch_load(latch_load),
        .pd_req(pd_req), .prog_done(prog_done), .prog_start(prog_start),
        .prog_cmd(prog_cmd), .pd_enter(pd_enter), .busy(busy), .seq_err(seq_err),
        .latch_loaded(latch_loaded)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at a falling edge, return at the next falling edge.
    task automatic cyc(input logic c, input logic s, input logic [7:0] d,
                       input logic o, input logic i, input logic l,
                       input logic p, input logic dn);
        ctl_wr = c; sts_wr = s; wr_data = d; other_acc = o; irq_cycle = i;
        latch_load = l; pd_req = p; prog_done = dn;
        @(negedge clk);
        ctl_wr = 0; sts_wr = 0; other_acc = 0; irq_cycle = 0;
        latch_load = 0; pd_req = 0; prog_done = 0;
    endtask

    task automatic idle();          cyc(0,0,8'h00,0,0,0,0,0); endtask
    task automatic ctl(input logic [7:0] d); cyc(1,0,d,0,0,0,0,0); endtask
    task automatic sts(input logic [7:0] d); cyc(0,1,d,0,0,0,0,0); endtask
    task automatic load();          cyc(0,0,8'h00,0,0,1,0,0); endtask
    task automatic done();          cyc(0,0,8'h00,0,0,0,0,1); endtask
    task automatic pdr();           cyc(0,0,8'h00,0,0,0,1,0); endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 busy", busy, 0); chk("R10 err", seq_err, 0);
        chk("R10 loaded", latch_loaded, 0); chk("R10 start", prog_start, 0);
        chk("R10 cmd", prog_cmd, 0); chk("R10 pd", pd_enter, 0);

        // R8 load strobe
        load(); chk("R8 loaded set", latch_loaded, 1);

        // R1/R4 sweep of every follow-up byte after a first key
        for (int v = 0; v < 256; v++) begin
            logic ok;
            ok = (v[7:4] == 4'hA) && (v[3:0] <= 4'h1);
            sts(8'h00); load();
            ctl(8'h50); ctl(v[7:0]);
            chk(ok ? "R1 start" : "R3/R4 start", prog_start, ok);
            chk(ok ? "R1 busy" : "R3/R4 busy", busy, ok);
            chk(ok ? "R7 err" : "R3/R4 err", seq_err, !ok);
            if (ok) begin
                chk("R4 cmd", prog_cmd, v[0]);
                idle(); chk("R1 one cycle", prog_start, 0);
                idle(); done();
                chk("R6 busy clear", busy, 0);
                chk("R8 loaded cleared", latch_loaded, 0);
            end
        end

        // R2 breaks between the keys
        sts(8'h00); load();
        ctl(8'h50); cyc(0,0,8'h00,1,0,0,0,0); chk("R2 other err", seq_err, 1);
        ctl(8'hA0); chk("R2 late key ignored", busy, 0);
        sts(8'h00);
        ctl(8'h50); cyc(1,0,8'hA0,0,1,0,0,0);
        chk("R2 irq err", seq_err, 1); chk("R2 irq no start", prog_start, 0);
        sts(8'h00);
        ctl(8'h50); idle(); chk("R2 idle err", seq_err, 1);
        ctl(8'hA0); chk("R2 idle no start", busy, 0);
        sts(8'h00);
        ctl(8'h50); sts(8'h00); chk("R2 status wr err", seq_err, 1);

        // R7 software clear behaviour
        sts(8'h02); chk("R7 bit1=1 keeps", seq_err, 1);
        sts(8'hFD); chk("R7 bit1=0 clears", seq_err, 0);
        ctl(8'h50); idle(); chk("R7 err set", seq_err, 1);
        ctl(8'h50); ctl(8'hA0); chk("R7 good seq clears", seq_err, 0);
        chk("R1 started", busy, 1);

        // R5 sequence while busy
        ctl(8'h50); ctl(8'hA1);
        chk("R5 busy err", seq_err, 1); chk("R5 busy no start", prog_start, 0);
        chk("R5 cmd kept", prog_cmd, 0);
        done(); chk("R6 done", busy, 0);
        // R6 stray done
        done(); chk("R6 stray done", busy, 0);
        // R5 no latch data
        sts(8'h00);
        ctl(8'h50); ctl(8'hA1);
        chk("R5 unloaded err", seq_err, 1); chk("R5 unloaded no start", busy, 0);

        // R9 immediate power-down
        load(); pdr();
        chk("R9 pd now", pd_enter, 1); chk("R9 latch cleared", latch_loaded, 0);
        idle(); chk("R9 pd pulse", pd_enter, 0);

        // R9 deferred power-down
        sts(8'h00); load();
        ctl(8'h50); ctl(8'hA1); chk("R9 setup busy", busy, 1);
        chk("R4 reset cmd", prog_cmd, 1);
        pdr(); chk("R9 held", pd_enter, 0);
        for (int k = 0; k < 4; k++) begin
            idle(); chk("R9 still held", pd_enter, 0);
        end
        done(); chk("R9 not yet", pd_enter, 0); chk("R6 cleared", busy, 0);
        idle(); chk("R9 deferred fire", pd_enter, 1);
        idle(); chk("R9 deferred pulse", pd_enter, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule